// File: doc/BRIEF.md
# CRT Vertical Timing Generator

This block produces the vertical blanking and vertical sync levels for a raster display. A line counter moves forward on strobes supplied by the horizontal timing logic: one strobe at the end of each scan line, and a second strobe halfway through each line. In progressive operation only the end-of-line strobe advances the counter. In interlaced operation both strobes advance it, so the count runs in half-line steps. When the total step count per field is odd, the vertical sync edge therefore falls mid-line in one field and at a line boundary in the next.

Software programs two 32-bit window words through a small synchronous port. Word 0 controls blanking and word 1 controls sync. Each word holds a turn-on field in bits 10:0 and a turn-off field in bits 26:16. Every field is coded as the target count minus one. An output changes on the advance that leaves the count equal to the field. The field count, the interlace enable and the sync polarity arrive as plain inputs. All written and input settings are staged. They become active only when the counter wraps, so a frame never runs with a mix of old and new settings.

Top module: `vtiming_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `vcount` is 0, `vblank`, `vsync` and `field` are 0, and `cfg_rdata` is 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` into word `cfg_addr` (0 = blank window, 1 = sync window). Only bits 10:0 (turn-on) and bits 26:16 (turn-off) are kept. `cfg_rdata` shows the stored word for `cfg_addr` one clock after the address is presented, with bits 31:27 and 15:11 reading 0.
- R3: An advance happens on a clock where `line_stb` is high, or where `half_stb` is high while interlace is active. On an advance, `vcount` goes up by 1, or goes to 0 if it was equal to the active total. `half_stb` has no effect while interlace is inactive.
- R4: On an advance that leaves a count equal to the blank turn-on field, `vblank` goes to 1 on that same clock edge. On an advance that leaves a count equal to the blank turn-off field, `vblank` goes to 0. At all other times `vblank` holds its value.
- R5: `vsync` follows the same rule as R4, using the sync window word.
- R6: If the turn-on and turn-off fields of a window are equal, turn-off takes priority and the window stays off.
- R7: While the active sync-invert setting is 1, `vsync` is the complement of the sync window level.
- R8: New window words, `total_lines`, `interlace_en` and `sync_invert` take effect from the first advance after a wrap (an advance from count equal to total). Until then the old settings govern every output.
- R9: On each wrap, `field` toggles if interlace was active and is cleared otherwise.
- R10: In interlaced mode with alternating half-line and end-of-line strobes and an odd number of steps per field, the strobe type that raises `vsync` alternates from field to field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | End-of-line strobe, one cycle wide |
| half_stb | input | 1 | Mid-line strobe, counted only in interlaced mode |
| cfg_we | input | 1 | Window word write enable |
| cfg_addr | input | 1 | Word select: 0 blank, 1 sync |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| total_lines | input | 11 | Last count value in a field (staged) |
| interlace_en | input | 1 | Interlace request (staged) |
| sync_invert | input | 1 | Sync polarity invert (staged) |
| vcount | output | 11 | Current vertical count |
| vblank | output | 1 | Vertical blank level |
| vsync | output | 1 | Vertical sync level after polarity |
| field | output | 1 | Interlace field indicator |

## Verification
The count, blank, sync and field outputs all change on the same clock edge that samples an advancing strobe. Read data appears one edge after the address. The driver raises a strobe at a falling edge and queues the expected outputs for that step. The monitor takes the item from the queue one nanosecond after the next rising edge, so each comparison lands in exactly the cycle the result is due. Read-back checks sample one nanosecond after the rising edge that follows the address change.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int REG_W     = 32;
  localparam int FLD_W     = 11;
  localparam int HI_LSB    = 16;
  localparam int N_WIN     = 2;
  localparam int ADDR_W    = 1;
  localparam int BLANK_IDX = 0;
  localparam int SYNC_IDX  = 1;

  typedef logic [FLD_W-1:0] line_t;

  typedef struct packed {
    line_t off_at;
    line_t on_at;
  } win_t;

  function automatic win_t win_unpack(input logic [REG_W-1:0] d);
    win_t w;
    w.on_at  = d[FLD_W-1:0];
    w.off_at = d[HI_LSB +: FLD_W];
    return w;
  endfunction

  function automatic logic [REG_W-1:0] win_pack(input win_t w);
    logic [REG_W-1:0] d;
    d = '0;
    d[FLD_W-1:0]       = w.on_at;
    d[HI_LSB +: FLD_W] = w.off_at;
    return d;
  endfunction

  function automatic logic [REG_W-1:0] live_mask();
    win_t w;
    w.on_at  = '1;
    w.off_at = '1;
    return win_pack(w);
  endfunction
endpackage

// File: rtl/vt_regs.sv
module vt_regs
  import vt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [REG_W-1:0]           cfg_rdata,
  input  logic                       load,
  input  line_t                      tot_in,
  input  logic                       il_in,
  input  logic                       inv_in,
  output win_t [N_WIN-1:0]           act_win,
  output line_t                      act_tot,
  output logic                       act_il,
  output logic                       act_inv
);
  localparam logic [REG_W-1:0] RSVD = ~live_mask();

  win_t [N_WIN-1:0] pend_q;
  logic [REG_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else if (cfg_we) begin
      pend_q[cfg_addr] <= win_unpack(cfg_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= win_pack(pend_q[cfg_addr]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_win <= '0;
      act_tot <= '0;
      act_il  <= 1'b0;
      act_inv <= 1'b0;
    end else if (load) begin
      act_win <= pend_q;
      act_tot <= tot_in;
      act_il  <= il_in;
      act_inv <= inv_in;
    end
  end

  assign cfg_rdata = rdata_q;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & RSVD) == '0);

  // R8
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_tot) && $stable(act_il) && $stable(act_inv));
endmodule

// File: rtl/vt_counter.sv
module vt_counter
  import vt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  line_t tot,
  input  logic  il,
  output line_t cnt,
  output logic  wrap,
  output logic  field
);
  line_t cnt_q;
  logic  field_q;

  assign wrap = adv && (cnt_q == tot);

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (adv) cnt_q <= (cnt_q == tot) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       field_q <= 1'b0;
    else if (wrap) field_q <= il ? ~field_q : 1'b0;
  end

  assign cnt   = cnt_q;
  assign field = field_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt_q));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !wrap) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R9
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(field_q));
endmodule

// File: rtl/vt_window.sv
module vt_window
  import vt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  line_t cur,
  input  win_t  win,
  input  logic  inv,
  output logic  level
);
  logic raw_q, raw_nx, out_q;

  always_comb begin
    raw_nx = raw_q;
    if (cur == win.off_at)     raw_nx = 1'b0;
    else if (cur == win.on_at) raw_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      out_q <= 1'b0;
    end else if (adv) begin
      raw_q <= raw_nx;
      out_q <= raw_nx ^ inv;
    end
  end

  assign level = out_q;

  // R4
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(out_q));

  // R6
  off_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && cur == win.off_at) |=> out_q == $past(inv));
endmodule

// File: rtl/vtiming_gen.sv
module vtiming_gen
  import vt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              line_stb,
  input  logic              half_stb,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [FLD_W-1:0]  total_lines,
  input  logic              interlace_en,
  input  logic              sync_invert,
  output logic [FLD_W-1:0]  vcount,
  output logic              vblank,
  output logic              vsync,
  output logic              field
);
  win_t [N_WIN-1:0] act_win;
  line_t            act_tot;
  logic             act_il, act_inv;
  logic             adv, wrap;
  line_t            cnt;
  logic [N_WIN-1:0] lvl;

  assign adv = line_stb | (act_il & half_stb);

  vt_regs u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .load(wrap),
    .tot_in(total_lines), .il_in(interlace_en), .inv_in(sync_invert),
    .act_win(act_win), .act_tot(act_tot),
    .act_il(act_il), .act_inv(act_inv)
  );

  vt_counter u_cnt (
    .clk(clk), .rst(rst), .adv(adv),
    .tot(act_tot), .il(act_il),
    .cnt(cnt), .wrap(wrap), .field(field)
  );

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    vt_window u_win (
      .clk(clk), .rst(rst), .adv(adv), .cur(cnt),
      .win(act_win[g]),
      .inv((g == SYNC_IDX) ? act_inv : 1'b0),
      .level(lvl[g])
    );
  end

  assign vcount = cnt;
  assign vblank = lvl[BLANK_IDX];
  assign vsync  = lvl[SYNC_IDX];

  // R3
  half_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_il && !line_stb) |=> $stable(vcount));

  // R4
  blank_off_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt == act_win[BLANK_IDX].off_at) |=> !vblank);

  // R5
  sync_on_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt == act_win[SYNC_IDX].on_at && cnt != act_win[SYNC_IDX].off_at)
      |=> vsync == !$past(act_inv));

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> vcount == '0);
endmodule

// File: tb/tb_vtiming_gen.sv
module tb_vtiming_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_stb = 1'b0, half_stb = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [10:0] total_lines = '0;
  logic        interlace_en = 1'b0, sync_invert = 1'b0;
  logic [10:0] vcount;
  logic        vblank, vsync, field;

  always #2.5 clk = ~clk;

  vtiming_gen dut (
    .clk(clk), .rst(rst), .line_stb(line_stb), .half_stb(half_stb),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .total_lines(total_lines),
    .interlace_en(interlace_en), .sync_invert(sync_invert),
    .vcount(vcount), .vblank(vblank), .vsync(vsync), .field(field)
  );

  typedef struct {
    logic [10:0] c;
    logic b, s, f, kind, r10;
  } item_t;

  item_t q[$];
  item_t it;
  logic  rise_kind[$];
  logic  prev_vs = 1'b0;
  int    checks = 0, errors = 0;
  logic  r10_on = 1'b0;

  // model state, from the requirements
  int          mc = 0, mtot = 0;
  logic        mil = 0, minv = 0, mf = 0, rb = 0, rs = 0, ob = 0, os = 0;
  logic [10:0] pon[2], poff[2], aon[2], aoff[2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      chk("R3 vcount", 32'(vcount), 32'(it.c));
      chk("R4/R6/R8 vblank", 32'(vblank), 32'(it.b));
      chk("R5/R6/R7/R8 vsync", 32'(vsync), 32'(it.s));
      chk("R9 field", 32'(field), 32'(it.f));
      if (it.r10 && !prev_vs && vsync) rise_kind.push_back(it.kind);
      prev_vs = vsync;
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    pon[a]  = d[10:0];
    poff[a] = d[26:16];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    @(posedge clk);
    #1;
    chk("R2 readback", cfg_rdata, exp);
  endtask

  // kind: 0 = end-of-line strobe, 1 = mid-line strobe
  task automatic step(input logic kind);
    item_t e;
    logic  adv, wr_;
    @(negedge clk);
    line_stb = !kind;
    half_stb = kind;
    adv = !kind || mil;
    if (adv) begin
      wr_ = (mc == mtot);
      if (mc == aoff[0]) rb = 0; else if (mc == aon[0]) rb = 1;
      if (mc == aoff[1]) rs = 0; else if (mc == aon[1]) rs = 1;
      ob = rb;
      os = rs ^ minv;
      if (wr_) mf = mil ? !mf : 1'b0;
      mc = wr_ ? 0 : mc + 1;
      if (wr_) begin
        aon = pon; aoff = poff;
        mtot = int'(total_lines); mil = interlace_en; minv = sync_invert;
      end
    end
    e.c = 11'(mc); e.b = ob; e.s = os; e.f = mf; e.kind = kind; e.r10 = r10_on;
    q.push_back(e);
    @(negedge clk);
    line_stb = 1'b0;
    half_stb = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int on, input int off);
    return (32'(off) << 16) | 32'(on);
  endfunction

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      pon[i] = '0; poff[i] = '0; aon[i] = '0; aoff[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vcount", 32'(vcount), 0);
    chk("R1 vblank", 32'(vblank), 0);
    chk("R1 vsync", 32'(vsync), 0);
    chk("R1 field", 32'(field), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 rdata", cfg_rdata, 0);
    chk("R1 vcount after release", 32'(vcount), 0);

    // R2: reserved bits dropped, both words read back
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, 32'h07FF_07FF);
    wr(1'b0, mk(3, 6));
    wr(1'b1, mk(4, 5));
    rd(1'b0, mk(3, 6));
    rd(1'b1, mk(4, 5));
    total_lines = 11'd9;

    // R3/R4/R5: progressive, mid-line strobes ignored
    for (int i = 0; i < 14; i++) step((i % 5) == 2);
    // R8: mid-frame rewrite only applies after the wrap
    wr(1'b0, mk(1, 2));
    for (int i = 0; i < 22; i++) step(1'b0);

    // R6/R7: equal fields keep sync off; inverted polarity
    wr(1'b1, mk(2, 2));
    sync_invert = 1'b1;
    for (int i = 0; i < 22; i++) step(1'b0);
    wr(1'b1, mk(1, 3));
    for (int i = 0; i < 22; i++) step(1'b0);

    // R9/R10: interlace, odd steps per field
    sync_invert  = 1'b0;
    interlace_en = 1'b1;
    total_lines  = 11'd8;
    wr(1'b0, mk(5, 8));
    wr(1'b1, mk(6, 7));
    while (!mil) step(1'b0);
    r10_on = 1'b1;
    for (int i = 0; i < 40; i++) step((i % 2) == 0);
    r10_on = 1'b0;
    repeat (3) @(posedge clk);

    chk("R10 sync rises seen", 32'(rise_kind.size() >= 3), 1);
    for (int i = 1; i < rise_kind.size(); i++)
      chk("R10 strobe type alternates", 32'(rise_kind[i] != rise_kind[i-1]), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule